// File: doc/BRIEF.md
# Packet Buffer Page Allocator

This block manages a 6 KiB packet memory for a 10 Mb/s Ethernet controller. The memory is cut into 24 pages of 256 bytes, and one pool of pages serves both directions. The host and the receive engine each ask for a number of pages. The block either returns a packet number, which is the index of the first page granted, or reports that the request failed. Pages go back to the pool when the host releases a packet. They also go back without any host action when the transmit engine reports a good send while automatic release is switched on.

The block also turns a packet number and an 11-bit byte pointer into a physical RAM byte address. The host can therefore stream a packet through one fixed data window as if its bytes were contiguous, even when its pages are scattered. Bits 10:8 of the pointer select the logical page of the packet and bits 7:0 select the byte within that page. A second address output gives the location of the byte that follows the pointer, so a 16-bit transfer works at any alignment, including one that crosses a page boundary. The pointer advances by one or two after each window access.

Top module: `pkt_page_alloc`

## Requirements
- R1: While reset is held and on the first cycle after it, all 24 pages are free (`free_pages` = 24), `alloc_done` and `rel_err` are low and `win_ptr` is 0.
- R2: A request for 1 to 6 pages that fits the free pool ends with a one-cycle `alloc_done` pulse, with `alloc_fail` low. The pages granted are the lowest-numbered free pages, `alloc_pkt` is the lowest of them, and `free_pages` falls by the page count.
- R3: A request for 0 or 7 pages, or for more pages than are free, ends with `alloc_done` and `alloc_fail` both high and takes no page, so `free_pages` does not change.
- R4: After the request cycle, `alloc_done` comes no later than 7 clock cycles later. The block grabs one page per cycle, and it is never grabbing for more than 6 cycles in a row.
- R5: Requests are latched. When both sources are pending, the receive request is served first. The host request is served next without being asked again, and `alloc_for_rx` is 1 for a receive grant and 0 for a host grant.
- R6: A host release of an allocated packet returns every page of that packet to the pool in the cycle after the request.
- R7: Pages are returned without host action only when `tx_done`, `tx_ok` and `auto_rel_en` are all high. A `tx_done` pulse with `tx_ok` low, or with `auto_rel_en` low, leaves the pool unchanged.
- R8: A release (host or automatic) of a packet number that is not currently allocated changes no page, and `rel_err` is high for the one following cycle.
- R9: `ram_addr_lo` equals P*256 + `win_ptr`[7:0], where P is the physical page stored at logical index `win_ptr`[10:8] of packet `win_pkt`.
- R10: `ram_addr_hi` is the translated address of `win_ptr`+1. Inside a page it is `ram_addr_lo`+1. At offset 255 it is offset 0 of the packet's next logical page.
- R11: `ptr_load` sets `win_ptr` to `ptr_value` and takes precedence over any access. Otherwise each `win_access` adds 2 to the pointer when `win_wide` is high and 1 when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_alloc_req | input | 1 | Host allocation request pulse |
| host_alloc_pages | input | 3 | Pages wanted by the host (valid 1..6) |
| rx_alloc_req | input | 1 | Receive engine allocation request pulse |
| rx_alloc_pages | input | 3 | Pages wanted by the receive engine |
| alloc_done | output | 1 | One-cycle pulse at the end of an allocation |
| alloc_fail | output | 1 | Result of the last allocation: 1 = failed |
| alloc_pkt | output | 5 | Packet number granted (first page index) |
| alloc_for_rx | output | 1 | Last result belongs to the receive engine |
| alloc_busy | output | 1 | A request is pending or being served |
| host_rel_req | input | 1 | Host release request pulse |
| host_rel_pkt | input | 5 | Packet number the host releases |
| tx_done | input | 1 | Transmit engine finished a packet |
| tx_ok | input | 1 | The finished send was successful |
| tx_pkt | input | 5 | Packet number the transmit engine finished |
| auto_rel_en | input | 1 | Enables release on successful send |
| rel_err | output | 1 | One-cycle flag: a release named an unallocated packet |
| free_pages | output | 5 | Number of free pages |
| win_pkt | input | 5 | Packet the data window reaches |
| ptr_load | input | 1 | Load the window pointer |
| ptr_value | input | 11 | Value loaded into the pointer |
| win_access | input | 1 | A window access took place this cycle |
| win_wide | input | 1 | Access width: 1 = 16-bit, 0 = 8-bit |
| win_ptr | output | 11 | Current window byte pointer |
| ram_addr_lo | output | 13 | Physical RAM address of the byte at the pointer |
| ram_addr_hi | output | 13 | Physical RAM address of the byte after the pointer |

## Verification
The bound checker covers the rules that hold on every cycle. These are the conservation of the free count (it drops by exactly one per page grab and holds when nothing is grabbed or released), the cap on consecutive grab cycles, the pointer steps, and the rule that the second window address sits next to the first whenever the pointer is not at the end of a page. A failed allocation is also checked to leave the pool as it was, and an error flag must follow a release request. Other behaviours need scenarios, so the bench drives them. These are the choice of the lowest free pages, a packet whose pages are scattered, the receive-before-host ordering, releases of unallocated or already freed packets, and address translation across a page boundary, all against hand-computed page numbers and addresses.

// File: rtl/pgalloc_pkg.sv
package pgalloc_pkg;

    localparam int NUM_PAGES  = 24;
    localparam int PAGE_BYTES = 256;
    localparam int MAX_CHAIN  = 6;

    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PG_W   = $clog2(NUM_PAGES);
    localparam int IDX_W  = $clog2(MAX_CHAIN);
    localparam int PTR_W  = IDX_W + OFF_W;
    localparam int ADDR_W = PG_W + OFF_W;
    localparam int CNT_W  = $clog2(NUM_PAGES + 1);

    typedef logic [PG_W-1:0]      page_t;
    typedef logic [IDX_W-1:0]     idx_t;
    typedef logic [PTR_W-1:0]     ptr_t;
    typedef logic [ADDR_W-1:0]    addr_t;
    typedef logic [CNT_W-1:0]     cnt_t;
    typedef logic [NUM_PAGES-1:0] pmask_t;

    typedef enum logic {ST_IDLE, ST_GRAB} alloc_st_e;

    typedef struct packed {
        logic pend;
        idx_t cnt;
    } req_slot_t;

    typedef struct packed {
        logic  en;
        page_t pkt;
        idx_t  idx;
        page_t page;
    } chain_wr_t;

    typedef struct packed {
        logic  en;
        page_t pkt;
        idx_t  len;
    } commit_t;

    function automatic cnt_t count_ones(pmask_t m);
        cnt_t c = '0;
        for (int i = 0; i < NUM_PAGES; i++) c = c + cnt_t'(m[i]);
        return c;
    endfunction

    function automatic page_t lowest_set(pmask_t m);
        page_t r = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) if (m[i]) r = page_t'(i);
        return r;
    endfunction

    function automatic logic count_ok(idx_t c);
        return (c != '0) && (c <= idx_t'(MAX_CHAIN));
    endfunction

endpackage

// File: rtl/pg_free_map.sv
module pg_free_map
    import pgalloc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   grab_en,
    input  page_t  grab_page,
    input  pmask_t rel_mask,
    output cnt_t   free_cnt,
    output page_t  low_page
);

    pmask_t free_q;
    pmask_t grab_mask;

    always_comb begin
        for (int i = 0; i < NUM_PAGES; i++)
            grab_mask[i] = grab_en && (grab_page == page_t'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) free_q <= '1;
        else     free_q <= (free_q | rel_mask) & ~grab_mask;
    end

    assign free_cnt = count_ones(free_q);
    assign low_page = lowest_set(free_q);

endmodule

// File: rtl/pg_chain_table.sv
module pg_chain_table
    import pgalloc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  chain_wr_t wr,
    input  commit_t   cm,
    input  logic      hrel_en,
    input  page_t     hrel_pkt,
    input  logic      trel_en,
    input  page_t     trel_pkt,
    input  page_t     win_pkt,
    input  ptr_t      win_ptr,
    output pmask_t    rel_mask,
    output logic      rel_bad,
    output addr_t     addr_lo,
    output addr_t     addr_hi
);

    localparam int NPORT = 2;

    page_t          chain [NUM_PAGES][MAX_CHAIN];
    idx_t           len   [NUM_PAGES];
    pmask_t         live;

    logic           rq_en  [NPORT];
    page_t          rq_pkt [NPORT];
    logic [NPORT-1:0] rq_ok;
    pmask_t         rq_mask [NPORT];

    assign rq_en[0]  = hrel_en;
    assign rq_pkt[0] = hrel_pkt;
    assign rq_en[1]  = trel_en;
    assign rq_pkt[1] = trel_pkt;

    // release lookup: one packet per port, unrolled over the chain slots
    always_comb begin
        for (int g = 0; g < NPORT; g++) begin
            rq_ok[g]   = 1'b0;
            rq_mask[g] = '0;
            for (int k = 0; k < NUM_PAGES; k++) begin
                if (rq_en[g] && rq_pkt[g] == page_t'(k) && live[k]) begin
                    rq_ok[g] = 1'b1;
                    for (int j = 0; j < MAX_CHAIN; j++)
                        if (idx_t'(j) < len[k])
                            rq_mask[g] = rq_mask[g] | (pmask_t'(1) << chain[k][j]);
                end
            end
        end
    end

    always_comb begin
        rel_mask = '0;
        rel_bad  = 1'b0;
        for (int g = 0; g < NPORT; g++) begin
            rel_mask = rel_mask | rq_mask[g];
            rel_bad  = rel_bad | (rq_en[g] && !rq_ok[g]);
        end
    end

    // window translation for the pointed byte and the byte after it
    ptr_t  ptr_nx;
    idx_t  idx_lo, idx_hi;
    page_t pg_lo, pg_hi;

    always_comb begin
        ptr_nx = win_ptr + ptr_t'(1);
        idx_lo = win_ptr[PTR_W-1:OFF_W];
        idx_hi = ptr_nx[PTR_W-1:OFF_W];
        pg_lo  = '0;
        pg_hi  = '0;
        for (int k = 0; k < NUM_PAGES; k++) begin
            for (int j = 0; j < MAX_CHAIN; j++) begin
                if (win_pkt == page_t'(k) && idx_lo == idx_t'(j)) pg_lo = chain[k][j];
                if (win_pkt == page_t'(k) && idx_hi == idx_t'(j)) pg_hi = chain[k][j];
            end
        end
        addr_lo = {pg_lo, win_ptr[OFF_W-1:0]};
        addr_hi = {pg_hi, ptr_nx[OFF_W-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
            for (int k = 0; k < NUM_PAGES; k++) begin
                len[k] <= '0;
                for (int j = 0; j < MAX_CHAIN; j++) chain[k][j] <= '0;
            end
        end else begin
            for (int k = 0; k < NUM_PAGES; k++) begin
                for (int j = 0; j < MAX_CHAIN; j++)
                    if (wr.en && wr.pkt == page_t'(k) && wr.idx == idx_t'(j))
                        chain[k][j] <= wr.page;
                if (cm.en && cm.pkt == page_t'(k)) begin
                    live[k] <= 1'b1;
                    len[k]  <= cm.len;
                end
                for (int g = 0; g < NPORT; g++)
                    if (rq_ok[g] && rq_pkt[g] == page_t'(k)) live[k] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pg_alloc_ctrl.sv
module pg_alloc_ctrl
    import pgalloc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      host_req,
    input  idx_t      host_cnt,
    input  logic      rx_req,
    input  idx_t      rx_cnt,
    input  cnt_t      free_cnt,
    input  page_t     low_page,
    output logic      grab_en,
    output page_t     grab_page,
    output chain_wr_t wr,
    output commit_t   cm,
    output logic      done,
    output logic      fail,
    output logic      for_rx,
    output page_t     pkt,
    output logic      busy
);

    alloc_st_e state;
    req_slot_t slot_h, slot_r;
    idx_t      need, taken;
    page_t     head;
    logic      cur_rx;

    logic serve_r, serve_h, fits, last;
    idx_t pick_cnt;

    always_comb begin
        serve_r  = (state == ST_IDLE) && slot_r.pend;
        serve_h  = (state == ST_IDLE) && !slot_r.pend && slot_h.pend;
        pick_cnt = serve_r ? slot_r.cnt : slot_h.cnt;
        fits     = count_ok(pick_cnt) && (free_cnt >= cnt_t'(pick_cnt));

        grab_en   = (state == ST_GRAB);
        grab_page = low_page;

        wr.en   = grab_en;
        wr.pkt  = (taken == '0) ? low_page : head;
        wr.idx  = taken;
        wr.page = low_page;

        last   = grab_en && (taken == idx_t'(need - idx_t'(1)));
        cm.en  = last;
        cm.pkt = wr.pkt;
        cm.len = need;

        busy = (state != ST_IDLE) || slot_h.pend || slot_r.pend;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            slot_h <= '0;
            slot_r <= '0;
            need   <= '0;
            taken  <= '0;
            head   <= '0;
            cur_rx <= 1'b0;
            done   <= 1'b0;
            fail   <= 1'b0;
            for_rx <= 1'b0;
            pkt    <= '0;
        end else begin
            done <= 1'b0;

            if (host_req)     slot_h <= '{pend: 1'b1, cnt: host_cnt};
            else if (serve_h) slot_h.pend <= 1'b0;
            if (rx_req)       slot_r <= '{pend: 1'b1, cnt: rx_cnt};
            else if (serve_r) slot_r.pend <= 1'b0;

            case (state)
                ST_IDLE: begin
                    if (serve_r || serve_h) begin
                        cur_rx <= serve_r;
                        if (fits) begin
                            state <= ST_GRAB;
                            need  <= pick_cnt;
                            taken <= '0;
                        end else begin
                            done   <= 1'b1;
                            fail   <= 1'b1;
                            for_rx <= serve_r;
                        end
                    end
                end
                ST_GRAB: begin
                    if (taken == '0) head <= low_page;
                    taken <= taken + idx_t'(1);
                    if (last) begin
                        state  <= ST_IDLE;
                        done   <= 1'b1;
                        fail   <= 1'b0;
                        pkt    <= wr.pkt;
                        for_rx <= cur_rx;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pkt_page_alloc.sv
module pkt_page_alloc
    import pgalloc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_alloc_req,
    input  logic [IDX_W-1:0]  host_alloc_pages,
    input  logic              rx_alloc_req,
    input  logic [IDX_W-1:0]  rx_alloc_pages,
    output logic              alloc_done,
    output logic              alloc_fail,
    output logic [PG_W-1:0]   alloc_pkt,
    output logic              alloc_for_rx,
    output logic              alloc_busy,
    input  logic              host_rel_req,
    input  logic [PG_W-1:0]   host_rel_pkt,
    input  logic              tx_done,
    input  logic              tx_ok,
    input  logic [PG_W-1:0]   tx_pkt,
    input  logic              auto_rel_en,
    output logic              rel_err,
    output logic [CNT_W-1:0]  free_pages,
    input  logic [PG_W-1:0]   win_pkt,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_value,
    input  logic              win_access,
    input  logic              win_wide,
    output logic [PTR_W-1:0]  win_ptr,
    output logic [ADDR_W-1:0] ram_addr_lo,
    output logic [ADDR_W-1:0] ram_addr_hi
);

    logic      grab_en;
    page_t     grab_page;
    page_t     low_page;
    pmask_t    rel_mask;
    logic      rel_bad;
    chain_wr_t chain_wr;
    commit_t   commit;
    logic      tx_rel;
    ptr_t      ptr_q;

    assign tx_rel = tx_done && tx_ok && auto_rel_en;

    pg_free_map u_map (
        .clk       (clk),
        .rst       (rst),
        .grab_en   (grab_en),
        .grab_page (grab_page),
        .rel_mask  (rel_mask),
        .free_cnt  (free_pages),
        .low_page  (low_page)
    );

    pg_alloc_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .host_req  (host_alloc_req),
        .host_cnt  (host_alloc_pages),
        .rx_req    (rx_alloc_req),
        .rx_cnt    (rx_alloc_pages),
        .free_cnt  (free_pages),
        .low_page  (low_page),
        .grab_en   (grab_en),
        .grab_page (grab_page),
        .wr        (chain_wr),
        .cm        (commit),
        .done      (alloc_done),
        .fail      (alloc_fail),
        .for_rx    (alloc_for_rx),
        .pkt       (alloc_pkt),
        .busy      (alloc_busy)
    );

    pg_chain_table u_tbl (
        .clk      (clk),
        .rst      (rst),
        .wr       (chain_wr),
        .cm       (commit),
        .hrel_en  (host_rel_req),
        .hrel_pkt (host_rel_pkt),
        .trel_en  (tx_rel),
        .trel_pkt (tx_pkt),
        .win_pkt  (win_pkt),
        .win_ptr  (ptr_q),
        .rel_mask (rel_mask),
        .rel_bad  (rel_bad),
        .addr_lo  (ram_addr_lo),
        .addr_hi  (ram_addr_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            rel_err <= 1'b0;
        end else begin
            rel_err <= rel_bad;
            if (ptr_load)        ptr_q <= ptr_value;
            else if (win_access) ptr_q <= ptr_q + (win_wide ? ptr_t'(2) : ptr_t'(1));
        end
    end

    assign win_ptr = ptr_q;

endmodule

// File: rtl/pkt_page_alloc_chk.sv
module pkt_page_alloc_chk
    import pgalloc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       grab_en,
    input logic       host_rel_req,
    input logic       tx_done,
    input logic       tx_ok,
    input logic       auto_rel_en,
    input logic       alloc_done,
    input logic       alloc_fail,
    input page_t      alloc_pkt,
    input logic       rel_err,
    input cnt_t       free_pages,
    input logic       ptr_load,
    input ptr_t       ptr_value,
    input logic       win_access,
    input logic       win_wide,
    input ptr_t       win_ptr,
    input addr_t      ram_addr_lo,
    input addr_t      ram_addr_hi
);

    logic rel_any;
    int   grab_run;

    assign rel_any = host_rel_req || (tx_done && tx_ok && auto_rel_en);

    always_ff @(posedge clk) begin
        if (rst)          grab_run <= 0;
        else if (grab_en) grab_run <= grab_run + 1;
        else              grab_run <= 0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (free_pages == cnt_t'(NUM_PAGES)) && !alloc_done && !rel_err && (win_ptr == '0));

    // R2
    grab_takes_one_chk: assert property (@(posedge clk) disable iff (rst)
        (grab_en && !rel_any) |=> (free_pages == cnt_t'($past(free_pages) - cnt_t'(1))));

    // R2
    grant_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_done && !alloc_fail) |-> (alloc_pkt < page_t'(NUM_PAGES)));

    // R3
    fail_keeps_pool_chk: assert property (@(posedge clk) disable iff (rst)
        (alloc_done && alloc_fail && !$past(rel_any)) |-> (free_pages == $past(free_pages)));

    // R4
    grab_run_chk: assert property (@(posedge clk) disable iff (rst)
        grab_run <= MAX_CHAIN);

    // R6
    quiet_pool_chk: assert property (@(posedge clk) disable iff (rst)
        (!grab_en && !rel_any) |=> $stable(free_pages));

    // R8
    err_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rel_err |-> $past(rel_any));

    // R10
    next_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (win_ptr[OFF_W-1:0] != '1) |-> (ram_addr_hi == addr_t'(ram_addr_lo + addr_t'(1))));

    // R11
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (win_access && !ptr_load) |=>
            (win_ptr == ptr_t'($past(win_ptr) + ($past(win_wide) ? ptr_t'(2) : ptr_t'(1)))));

    // R11
    ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_load |=> (win_ptr == $past(ptr_value)));

endmodule

bind pkt_page_alloc pkt_page_alloc_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .grab_en      (grab_en),
    .host_rel_req (host_rel_req),
    .tx_done      (tx_done),
    .tx_ok        (tx_ok),
    .auto_rel_en  (auto_rel_en),
    .alloc_done   (alloc_done),
    .alloc_fail   (alloc_fail),
    .alloc_pkt    (alloc_pkt),
    .rel_err      (rel_err),
    .free_pages   (free_pages),
    .ptr_load     (ptr_load),
    .ptr_value    (ptr_value),
    .win_access   (win_access),
    .win_wide     (win_wide),
    .win_ptr      (win_ptr),
    .ram_addr_lo  (ram_addr_lo),
    .ram_addr_hi  (ram_addr_hi)
);

// File: tb/sim_pkt_page_alloc.sv
`timescale 1ns/1ps
module sim_pkt_page_alloc;
    import pgalloc_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_alloc_req = 0, rx_alloc_req = 0;
    logic [IDX_W-1:0] host_alloc_pages = '0, rx_alloc_pages = '0;
    logic alloc_done, alloc_fail, alloc_for_rx, alloc_busy, rel_err;
    logic [PG_W-1:0] alloc_pkt;
    logic host_rel_req = 0, tx_done = 0, tx_ok = 0, auto_rel_en = 0;
    logic [PG_W-1:0] host_rel_pkt = '0, tx_pkt = '0, win_pkt = '0;
    logic [CNT_W-1:0] free_pages;
    logic ptr_load = 0, win_access = 0, win_wide = 0;
    logic [PTR_W-1:0] ptr_value = '0, win_ptr;
    logic [ADDR_W-1:0] ram_addr_lo, ram_addr_hi;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    pkt_page_alloc u0 (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_alloc(input logic rx, input int n, output int lat);
        @(negedge clk);
        if (rx) begin rx_alloc_req = 1; rx_alloc_pages = IDX_W'(n); end
        else    begin host_alloc_req = 1; host_alloc_pages = IDX_W'(n); end
        @(negedge clk);
        rx_alloc_req = 0;
        host_alloc_req = 0;
        lat = 0;
        while (!alloc_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic do_rel(input int p);
        @(negedge clk);
        host_rel_req = 1;
        host_rel_pkt = PG_W'(p);
        @(negedge clk);
        host_rel_req = 0;
    endtask

    task automatic do_tx(input int p, input logic autom, input logic ok);
        @(negedge clk);
        tx_done = 1; tx_ok = ok; tx_pkt = PG_W'(p); auto_rel_en = autom;
        @(negedge clk);
        tx_done = 0; tx_ok = 0;
    endtask

    task automatic set_ptr(input int p, input int v);
        @(negedge clk);
        win_pkt = PG_W'(p);
        ptr_load = 1;
        ptr_value = PTR_W'(v);
        @(negedge clk);
        ptr_load = 0;
    endtask

    // op(2) arg(5) flag(1) exp_fail(1) exp_pkt(5) exp_free(5) exp_err(1)
    localparam logic [1:0] OP_AH = 2'd0, OP_AR = 2'd1, OP_REL = 2'd2, OP_TX = 2'd3;
    localparam int NV = 19;
    localparam logic [19:0] VEC [0:NV-1] = '{
        {OP_AH,  5'd3,  1'b0, 1'b0, 5'd0,  5'd21, 1'b0},
        {OP_AR,  5'd6,  1'b0, 1'b0, 5'd3,  5'd15, 1'b0},
        {OP_AH,  5'd6,  1'b0, 1'b0, 5'd9,  5'd9,  1'b0},
        {OP_AH,  5'd6,  1'b0, 1'b0, 5'd15, 5'd3,  1'b0},
        {OP_AH,  5'd4,  1'b0, 1'b1, 5'd0,  5'd3,  1'b0},
        {OP_AH,  5'd3,  1'b0, 1'b0, 5'd21, 5'd0,  1'b0},
        {OP_AR,  5'd1,  1'b0, 1'b1, 5'd0,  5'd0,  1'b0},
        {OP_REL, 5'd3,  1'b0, 1'b0, 5'd0,  5'd6,  1'b0},
        {OP_REL, 5'd3,  1'b0, 1'b0, 5'd0,  5'd6,  1'b1},
        {OP_AH,  5'd2,  1'b0, 1'b0, 5'd3,  5'd4,  1'b0},
        {OP_TX,  5'd9,  1'b1, 1'b0, 5'd0,  5'd10, 1'b0},
        {OP_TX,  5'd0,  1'b0, 1'b0, 5'd0,  5'd10, 1'b0},
        {OP_REL, 5'd0,  1'b0, 1'b0, 5'd0,  5'd13, 1'b0},
        {OP_AH,  5'd6,  1'b0, 1'b0, 5'd0,  5'd7,  1'b0},
        {OP_AH,  5'd0,  1'b0, 1'b1, 5'd0,  5'd7,  1'b0},
        {OP_AH,  5'd7,  1'b0, 1'b1, 5'd0,  5'd7,  1'b0},
        {OP_REL, 5'd30, 1'b0, 1'b0, 5'd0,  5'd7,  1'b1},
        {OP_TX,  5'd9,  1'b1, 1'b0, 5'd0,  5'd7,  1'b1},
        {OP_AR,  5'd1,  1'b0, 1'b0, 5'd8,  5'd6,  1'b0}
    };

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1: reset state, sampled while reset is held
        chk("R1 free", int'(free_pages), 24);
        chk("R1 done", int'(alloc_done), 0);
        chk("R1 ptr", int'(win_ptr), 0);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            case (v[19:18])
                OP_AH, OP_AR: begin
                    do_alloc(v[19:18] == OP_AR, int'(v[17:13]), lat);
                    chk("R4 latency bound", int'(lat <= 7), 1);
                    if (v[11]) begin
                        chk("R3 fail flag", int'(alloc_fail), 1);
                        chk("R3 pool untouched", int'(free_pages), int'(v[5:1]));
                    end else begin
                        chk("R2 fail flag", int'(alloc_fail), 0);
                        chk("R2 packet number", int'(alloc_pkt), int'(v[10:6]));
                        chk("R2 free count", int'(free_pages), int'(v[5:1]));
                        chk("R5 source flag", int'(alloc_for_rx), int'(v[19:18] == OP_AR));
                    end
                end
                OP_REL: begin
                    do_rel(int'(v[17:13]));
                    chk(v[0] ? "R8 error flag" : "R6 error flag", int'(rel_err), int'(v[0]));
                    chk(v[0] ? "R8 pool untouched" : "R6 pages returned", int'(free_pages), int'(v[5:1]));
                end
                default: begin
                    do_tx(int'(v[17:13]), v[12], 1'b1);
                    chk(v[0] ? "R8 error flag" : "R7 error flag", int'(rel_err), int'(v[0]));
                    chk("R7 free count", int'(free_pages), int'(v[5:1]));
                end
            endcase
        end

        // R7: failed send with auto release enabled leaves packet 3 in place
        do_tx(3, 1'b1, 1'b0);
        chk("R7 failed send keeps pages", int'(free_pages), 6);
        chk("R7 no error", int'(rel_err), 0);

        // R9/R10: packet 0 holds pages 0,1,2,5,6,7
        set_ptr(0, 11'h2FF);
        chk("R9 low address", int'(ram_addr_lo), 2*256 + 255);
        chk("R10 page crossing", int'(ram_addr_hi), 5*256);
        @(negedge clk); win_access = 1; win_wide = 1;
        @(negedge clk); win_access = 0;
        chk("R11 wide step", int'(win_ptr), 11'h301);
        chk("R9 after step", int'(ram_addr_lo), 5*256 + 1);
        chk("R10 inside page", int'(ram_addr_hi), 5*256 + 2);
        @(negedge clk); win_access = 1; win_wide = 0;
        @(negedge clk); win_access = 0;
        chk("R11 byte step", int'(win_ptr), 11'h302);
        set_ptr(0, 11'h5FF);
        chk("R9 last chain slot", int'(ram_addr_lo), 7*256 + 255);
        set_ptr(3, 11'h0FF);
        chk("R9 packet 3", int'(ram_addr_lo), 3*256 + 255);
        chk("R10 packet 3 crossing", int'(ram_addr_hi), 4*256);
        @(negedge clk); ptr_load = 1; ptr_value = 11'h123; win_access = 1; win_wide = 1;
        @(negedge clk); ptr_load = 0; win_access = 0;
        chk("R11 load wins", int'(win_ptr), 11'h123);

        // R1 again, then R5 ordering from a clean pool
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 free after reset", int'(free_pages), 24);
        chk("R1 ptr after reset", int'(win_ptr), 0);
        host_alloc_req = 1; host_alloc_pages = 3'd2;
        rx_alloc_req = 1;   rx_alloc_pages = 3'd1;
        @(negedge clk);
        host_alloc_req = 0; rx_alloc_req = 0;
        lat = 0;
        while (!alloc_done && lat < 40) begin @(negedge clk); lat++; end
        chk("R5 receive first", int'(alloc_for_rx), 1);
        chk("R5 receive packet", int'(alloc_pkt), 0);
        @(negedge clk);
        lat = 0;
        while (!alloc_done && lat < 40) begin @(negedge clk); lat++; end
        chk("R5 host second", int'(alloc_for_rx), 0);
        chk("R5 host packet", int'(alloc_pkt), 1);
        chk("R5 free count", int'(free_pages), 21);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule